// File: doc/BRIEF.md
# Cascadable Registered Command Buffer with Split Parity Check

This block is one slice of a registered command/address buffer. Each slice captures a 14-bit word on the rising clock edge whenever either of its two active-low select inputs is asserted. Two slices are wired in cascade so that they can check parity over a 28-bit word plus one parity bit. A static role input picks what a slice does. A first-role slice folds its own word and an external parity bit into one partial-parity bit. It registers that bit and drives it out. A second-role slice takes that bit on its parity input, combines it with the parity of its own word, and drives an active-low error flag.

The error flag has a fixed latency from the edge that captured the command. Once it drops, it stays low for a parameterised minimum number of cycles, and a further error in that window restarts the window. An asynchronous active-low reset clears every register and releases the flag at once.

Top module: `regbuf_slice`

## Requirements
- R1: On a rising edge where `csAN` or `csBN` (or both) is low, `dataOut` takes the value of `dataIn` presented at that edge.
- R2: On a rising edge where both `csAN` and `csBN` are high, `dataOut` keeps its previous value.
- R3: With `roleSel` = 0 (first role), `partPar` after edge n+1 equals the XOR of the 14 `dataOut` bits and the `parIn` value captured at load edge n. It holds that value as long as no new load occurs.
- R4: With `roleSel` = 1 (second role), `partPar` is held at 0.
- R5: With `roleSel` = 0, `errN` stays high.
- R6: Parity is odd over the 28 data bits of both slices plus the parity bit. An even count of ones is an error, and an odd count is not.
- R7: For a word loaded at edge n, an error drives `errN` low right after edge n+2, and the flag is therefore valid during the cycle that ends at edge n+3.
- R8: Once `errN` goes low with no further error, it stays low for exactly 2 cycles (`HOLD_CYC`) and then returns high.
- R9: A new error detected while `errN` is low restarts the 2-cycle minimum hold.
- R10: `rstN` low immediately forces `dataOut` and `partPar` to 0 and `errN` to 1, whatever the hold count.
- R11: Only cycles that loaded a word are checked. Words held through deselected cycles are not checked again, and no error appears after reset until a word has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| roleSel | input | 1 | 0 = first (partial-parity) role, 1 = second (checking) role |
| csAN | input | 1 | Select A, active low |
| csBN | input | 1 | Select B, active low |
| dataIn | input | 14 | Command/address word in |
| parIn | input | 1 | Parity bit (first role) or upstream partial parity (second role) |
| dataOut | output | 14 | Registered word out |
| partPar | output | 1 | Registered partial parity; 0 in second role |
| errN | output | 1 | Latched parity error flag, active low |

## Verification
The hardest state to reach is a second error that lands while the flag is already low. Reaching it needs two loads two edges apart, each with a wrong parity bit, so that both checks fall inside the hold window. The bench also asserts reset in the exact cycle where the flag is low and the hold count is still nonzero, and it samples the flag one time unit later to confirm the release is asynchronous. All of this runs through two slices in cascade, which ties the first slice's partial-parity timing to the second slice's check.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
  localparam logic ROLE_FIRST  = 1'b0;
  localparam logic ROLE_SECOND = 1'b1;

  typedef struct packed {
    logic loadEn;     // capture dataIn this edge
    logic firstRole;  // slice forms and drives the partial parity
  } dpStrobe_t;
endpackage

// File: rtl/regbuf_datapath.sv
module regbuf_datapath
  import regbuf_pkg::*;
#(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             parIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             partPar,
  output logic             parityOdd
);
  logic [WIDTH-1:0] dataReg;
  logic             parReg;
  logic             sumStage;

  // word and (first role only) parity bit capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      parReg  <= 1'b0;
    end else if (strobe.loadEn) begin
      dataReg <= dataIn;
      parReg  <= strobe.firstRole ? parIn : 1'b0;
    end
  end

  // one-stage fold: partial parity in first role, local word parity in second
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumStage <= 1'b0;
    else       sumStage <= (^dataReg) ^ parReg;
  end

  assign dataOut   = dataReg;
  assign partPar   = strobe.firstRole ? sumStage : 1'b0;
  // total ones over both words and parity bit: 1 means odd (good)
  assign parityOdd = sumStage ^ parIn;

  // R2: a deselected edge leaves the word untouched
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(dataOut));
endmodule

// File: rtl/regbuf_ctrl.sv
module regbuf_ctrl
  import regbuf_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      roleSel,
  input  logic      csAN,
  input  logic      csBN,
  input  logic      parityOdd,
  output dpStrobe_t strobe,
  output logic      errN
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic             loadEn;
  logic             vld1;
  logic             vld2;
  logic             checkEn;
  logic             errHit;
  logic             errReg;
  logic [CNT_W-1:0] holdCnt;

  assign loadEn = !(csAN && csBN);

  // marks which pipeline slots carry a freshly loaded word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
    end else begin
      vld1 <= loadEn;
      vld2 <= vld1;
    end
  end

  assign checkEn = vld2 && (roleSel == ROLE_SECOND);
  assign errHit  = checkEn && !parityOdd;

  // sticky flag with minimum low time, restarted by each new hit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg  <= 1'b1;
      holdCnt <= '0;
    end else if (errHit) begin
      errReg  <= 1'b0;
      holdCnt <= CNT_W'(HOLD_CYC - 1);
    end else if (!errReg) begin
      if (holdCnt == '0) errReg  <= 1'b1;
      else               holdCnt <= holdCnt - 1'b1;
    end
  end

  assign strobe.loadEn    = loadEn;
  assign strobe.firstRole = (roleSel == ROLE_FIRST);
  assign errN             = errReg;

  // R8: a falling flag is still low one edge later
  a_r8_min_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errN) |=> !errN);

  // R9: every detected error yields two low cycles from that point
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    errHit |=> !errN ##1 !errN);

  // R7: a fall traces back to a load three edges earlier
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errN) |-> $past(loadEn, 3));

  // R5: first-role slice never flags
  a_r5_first_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (roleSel == ROLE_FIRST) && $past(roleSel == ROLE_FIRST) && $past(errN) |-> errN);
endmodule

// File: rtl/regbuf_slice.sv
module regbuf_slice
  import regbuf_pkg::*;
#(
  parameter int WIDTH    = 14,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             roleSel,
  input  logic             csAN,
  input  logic             csBN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             parIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             partPar,
  output logic             errN
);
  dpStrobe_t strobe;
  logic      parityOdd;

  regbuf_ctrl #(.HOLD_CYC(HOLD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .roleSel(roleSel), .csAN(csAN), .csBN(csBN),
    .parityOdd(parityOdd), .strobe(strobe), .errN(errN)
  );

  regbuf_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .parIn(parIn),
    .dataOut(dataOut), .partPar(partPar), .parityOdd(parityOdd)
  );
endmodule

// File: tb/sim_regbuf_slice.sv
module sim_regbuf_slice;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csAN = 1'b1, csBN = 1'b1;
  logic [13:0] dA = '0, dB = '0;
  logic        parBit = 1'b0;
  logic [13:0] qA, qB;
  logic        ppA, ppB, errA, errB;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  // first role slice
  regbuf_slice u1 (.clk(clk), .rstN(rstN), .roleSel(1'b0), .csAN(csAN), .csBN(csBN),
    .dataIn(dA), .parIn(parBit), .dataOut(qA), .partPar(ppA), .errN(errA));
  // second role slice, fed by the first slice's partial parity
  regbuf_slice u0 (.clk(clk), .rstN(rstN), .roleSel(1'b1), .csAN(csAN), .csBN(csBN),
    .dataIn(dB), .parIn(ppA), .dataOut(qB), .partPar(ppB), .errN(errB));

  typedef struct {
    logic [13:0] eA;
    logic [13:0] eB;
    logic        ePart;
    logic        eErr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench model state (values after the latest modelled edge)
  logic [13:0] mA, mB;
  logic mParA, mSumA, mSumB, mV1, mV2, mErr;
  int mCnt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mA = '0; mB = '0; mParA = 0; mSumA = 0; mSumB = 0;
    mV1 = 0; mV2 = 0; mErr = 1; mCnt = 0;
  endtask

  task automatic push(string tag);
    exp_t e;
    e.eA = mA; e.eB = mB; e.ePart = mSumA; e.eErr = mErr; e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: apply one cycle of stimulus, advance the model, queue expectation
  task automatic step(logic a, logic b, logic [13:0] wa, logic [13:0] wb,
                      logic badPar, string tag);
    logic load, hit, nSumA, nSumB, p;
    @(negedge clk);
    p = ~((^wa) ^ (^wb)) ^ badPar;  // R6: good bit makes total ones odd
    rstN = 1'b1; csAN = a; csBN = b; dA = wa; dB = wb; parBit = p;
    load  = !(a && b);
    hit   = mV2 && ((mSumA ^ mSumB) == 1'b0);
    nSumA = (^mA) ^ mParA;
    nSumB = ^mB;
    if (hit) begin
      mErr = 0; mCnt = HOLD - 1;
    end else if (!mErr) begin
      if (mCnt == 0) mErr = 1; else mCnt--;
    end
    mV2 = mV1; mV1 = load;
    mSumA = nSumA; mSumB = nSumB;
    if (load) begin mA = wa; mB = wb; mParA = p; end
    push(tag);
  endtask

  task automatic resetPulse();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R10 errN", {31'b0, errB}, 32'd1);
    chk("R10 dataOut", {18'b0, qB}, 32'd0);
    chk("R10 partPar", {31'b0, ppA}, 32'd0);
    modelReset();
    push("R10");
  endtask

  // monitor: pop and compare away from the active edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk({e.tag, " R1 first word"}, {18'b0, qA}, {18'b0, e.eA});
        chk({e.tag, " R1 second word"}, {18'b0, qB}, {18'b0, e.eB});
        chk({e.tag, " R3 partPar"}, {31'b0, ppA}, {31'b0, e.ePart});
        chk({e.tag, " R4 second partPar"}, {31'b0, ppB}, 32'd0);
        chk({e.tag, " R5 first errN"}, {31'b0, errA}, 32'd1);
        chk({e.tag, " errN"}, {31'b0, errB}, {31'b0, e.eErr});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    modelReset();
    resetPulse();
    // R11: idle after reset, no word loaded, no flag
    for (int i = 0; i < 4; i++) step(1, 1, 14'h3FFF, 14'h0001, 1, "R11");
    // R1 R6: good loads through each select combination
    for (int i = 0; i < 6; i++)
      step(i[0], ~i[0] & i[1], 14'(i * 777 + 5), 14'(i * 4099 + 3), 0, "R6");
    step(0, 1, 14'h2AAA, 14'h1555, 0, "R1");
    step(1, 0, 14'h0F0F, 14'h30F0, 0, "R1");
    // R2: hold through deselect
    for (int i = 0; i < 3; i++) step(1, 1, 14'h1234, 14'h0777, 0, "R2");
    // R7 R8: single bad word, then good words
    step(0, 0, 14'h0101, 14'h2020, 1, "R7");
    for (int i = 0; i < 6; i++) step(0, 0, 14'(i + 9), 14'(i * 33), 0, "R8");
    // R9: second error two edges later lands in the hold window
    step(0, 0, 14'h0003, 14'h1000, 1, "R9");
    step(0, 0, 14'h0007, 14'h0001, 0, "R9");
    step(0, 1, 14'h3C00, 14'h00C3, 1, "R9");
    for (int i = 0; i < 6; i++) step(0, 0, 14'(i * 5), 14'(i * 9 + 1), 0, "R9");
    // R11: bad word then deselect; held word is not rechecked
    step(0, 0, 14'h1111, 14'h0222, 1, "R11");
    for (int i = 0; i < 6; i++) step(1, 1, 14'h0000, 14'h0000, 0, "R11");
    // R10: reset while the flag is low
    step(0, 0, 14'h0055, 14'h0AA0, 1, "R10");
    step(0, 0, 14'h0001, 14'h0002, 0, "R10");
    step(0, 0, 14'h0004, 14'h0008, 0, "R10");
    resetPulse();
    for (int i = 0; i < 4; i++) step(0, 0, 14'(i * 100), 14'(i * 200), 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 1, 14'h0, 14'h0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule